// File: doc/BRIEF.md
# Compressed immediate operand generator

This combinational unit forms the 64-bit immediate operand for the immediate format of 16-bit compressed instructions. The decoder passes it the 3-bit major opcode, the 1-bit minor opcode, a 5-bit high immediate field, a 3-bit low immediate field and the 3-bit base-register field. The unit picks how many high bits take part and sign-extends the result. It then scales the value by the access size or by the shifted-add factor, and removes a fixed bias for stack-relative accesses.

Beside the value, the unit reports several things about the instruction:
- its operation class;
- the access width;
- the width chosen by a compare;
- whether the base operand is a literal zero (load-immediate);
- whether the base is the stack pointer (register 1);
- whether the encoding is reserved and must trap.

The outputs have meaning only while the mode tracker reports the immediate format (`fmt_valid`). When `fmt_valid` is low, every output is held at zero.

Top module: `cimm_gen`

## Requirements
- R1: While `fmt_valid` is 0, `imm_out`, `op_class` and all five flag outputs are 0, whatever the other inputs are.
- R2: Opcode 010.0 (add-immediate) gives `op_class`=1, and `imm_out` is the sign extension of {`hi_field[0]`, `lo_field`}, which lies in -8..+7. The upper four bits of `hi_field` have no effect.
- R3: For add-immediate, `use_zero_base` is 1 exactly when `reg_a` is 0 (load-immediate), and `reserved_enc` stays 0.
- R4: Opcode 001.0 (shifted add) gives `op_class`=2, and `imm_out` is the sign extension of {`hi_field`, `lo_field`, 3'b000}, which lies in -1024..+1016. When `reg_a` is 0, `reserved_enc` is 1.
- R5: Opcode 010.1 (compare-immediate) gives `op_class`=3, and `imm_out` is the sign extension of {`hi_field[3:0]`, `lo_field`}. `cmp_dword` is the inverse of `hi_field[4]` (0 selects a doubleword compare, 1 selects a word compare).
- R6: Major opcodes 100, 101, 110 and 111 set `op_class` to 5 (integer store), 4 (integer load), 7 (FP store) and 6 (FP load). The access is 8 bytes for minor 1 under majors 100, 110 and 111, and for minor 0 under major 101; otherwise it is 4 bytes. `acc_dword` shows the width. `imm_out` is the sign extension of {`hi_field`, `lo_field`}, shifted left by 3 for an 8-byte access and by 2 for a 4-byte access.
- R7: Opcode 011.0 is a stack-relative integer load (`op_class`=4) and 011.1 is a stack-relative integer store (`op_class`=5). Both set `use_sp_base`. The access is 8 bytes when `hi_field[4]` is 0 for the load, or when `hi_field[4]` is 1 for the store. `imm_out` is the sign extension of {`hi_field[3:0]`, `lo_field`}, scaled by the access size, minus 256.
- R8: Opcodes 000.x and 001.1 are not immediate operations. They give `op_class`=0, `imm_out`=0 and all flags 0.
- R9: At most one of `use_zero_base`, `use_sp_base` and `reserved_enc` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_valid | input | 1 | Mode tracker reports the immediate format |
| op_major | input | 3 | Compressed major opcode |
| op_minor | input | 1 | Compressed minor opcode |
| hi_field | input | 5 | High immediate bits |
| lo_field | input | 3 | Low immediate bits |
| reg_a | input | 3 | Base-register field |
| imm_out | output | 64 | Sign-extended, scaled, biased immediate |
| op_class | output | 3 | 0 none, 1 add-imm, 2 shifted add, 3 compare, 4 load, 5 store, 6 FP load, 7 FP store |
| acc_dword | output | 1 | Memory access is 8 bytes (0 means 4 bytes or not memory) |
| cmp_dword | output | 1 | Compare is doubleword |
| use_zero_base | output | 1 | Base operand is literal zero |
| use_sp_base | output | 1 | Base operand is the stack pointer |
| reserved_enc | output | 1 | Reserved encoding, must trap |

## Verification
Each opcode is driven with the most negative and most positive field patterns. This shows whether the right number of high bits is used and whether the sign comes from the right bit. Small positive values such as 1 or 8 separate a shift of 2 from a shift of 3, so they catch an access-width or minor-opcode swap. Stack-relative cases near the bias (-4, -248, -260) show the subtraction of 256 and the width-select polarity, which is opposite for loads and stores. The zero base field is tried on add-immediate, shifted add and a memory form to tell the load-immediate case from the reserved case. The same opcodes with `fmt_valid` low confirm that the outputs stay at zero.

// File: rtl/cimm_pkg.sv
package cimm_pkg;

    typedef enum logic [2:0] {
        IC_NONE   = 3'd0,
        IC_ADDI   = 3'd1,
        IC_ADDIS  = 3'd2,
        IC_CMPI   = 3'd3,
        IC_LOAD   = 3'd4,
        IC_STORE  = 3'd5,
        IC_FLOAD  = 3'd6,
        IC_FSTORE = 3'd7
    } imm_class_e;

    // which slice of the high field joins the low field
    typedef enum logic [1:0] {
        FS_SHORT = 2'd0,   // one high bit
        FS_MID   = 2'd1,   // all but the top high bit
        FS_FULL  = 2'd2    // whole high field
    } field_sel_e;

    typedef struct packed {
        imm_class_e cls;
        field_sel_e fsel;
        logic [1:0] shamt;
        logic       dword;
        logic       sp_rel;
        logic       cmp_dw;
    } imm_dec_t;

    localparam logic [1:0] SH_NONE  = 2'd0;
    localparam logic [1:0] SH_WORD  = 2'd2;
    localparam logic [1:0] SH_DWORD = 2'd3;
    localparam logic [1:0] SH_ADDIS = 2'd3;

    function automatic logic [1:0] size_shift(input logic dw);
        return dw ? SH_DWORD : SH_WORD;
    endfunction

    function automatic logic is_mem(input imm_class_e c);
        return (c == IC_LOAD) || (c == IC_STORE) ||
               (c == IC_FLOAD) || (c == IC_FSTORE);
    endfunction

endpackage

// File: rtl/cimm_classify.sv
module cimm_classify
    import cimm_pkg::*;
(
    input  logic [2:0] op_major,
    input  logic       op_minor,
    input  logic       hi_msb,
    output imm_dec_t   dec
);
    logic mem_dw;

    // major 101 (integer load) has the width polarity reversed
    assign mem_dw = op_minor ^ (op_major == 3'b101);

    always_comb begin
        dec        = '0;
        dec.cls    = IC_NONE;
        dec.fsel   = FS_FULL;
        dec.shamt  = SH_NONE;
        unique case ({op_major, op_minor})
            4'b001_0: begin
                dec.cls   = IC_ADDIS;
                dec.fsel  = FS_FULL;
                dec.shamt = SH_ADDIS;
            end
            4'b010_0: begin
                dec.cls  = IC_ADDI;
                dec.fsel = FS_SHORT;
            end
            4'b010_1: begin
                dec.cls    = IC_CMPI;
                dec.fsel   = FS_MID;
                dec.cmp_dw = ~hi_msb;
            end
            4'b011_0: begin
                dec.cls    = IC_LOAD;
                dec.fsel   = FS_MID;
                dec.sp_rel = 1'b1;
                dec.dword  = ~hi_msb;
                dec.shamt  = size_shift(~hi_msb);
            end
            4'b011_1: begin
                dec.cls    = IC_STORE;
                dec.fsel   = FS_MID;
                dec.sp_rel = 1'b1;
                dec.dword  = hi_msb;
                dec.shamt  = size_shift(hi_msb);
            end
            default: begin
                if (op_major[2]) begin
                    unique case (op_major[1:0])
                        2'b00:   dec.cls = IC_STORE;
                        2'b01:   dec.cls = IC_LOAD;
                        2'b10:   dec.cls = IC_FSTORE;
                        default: dec.cls = IC_FLOAD;
                    endcase
                    dec.fsel  = FS_FULL;
                    dec.dword = mem_dw;
                    dec.shamt = size_shift(mem_dw);
                end
            end
        endcase
    end

endmodule

// File: rtl/cimm_assemble.sv
module cimm_assemble
    import cimm_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int HI_W    = 5,
    parameter int LO_W    = 3,
    parameter int SP_BIAS = 256
) (
    input  imm_dec_t          dec,
    input  logic [HI_W-1:0]   hi_field,
    input  logic [LO_W-1:0]   lo_field,
    output logic [XLEN-1:0]   imm
);
    localparam int SHORT_W = LO_W + 1;
    localparam int MID_W   = HI_W - 1 + LO_W;
    localparam int FULL_W  = HI_W + LO_W;

    logic [SHORT_W-1:0] raw_short;
    logic [MID_W-1:0]   raw_mid;
    logic [FULL_W-1:0]  raw_full;
    logic [XLEN-1:0]    ext_short, ext_mid, ext_full;
    logic [XLEN-1:0]    picked, scaled;

    assign raw_short = {hi_field[0], lo_field};
    assign raw_mid   = {hi_field[HI_W-2:0], lo_field};
    assign raw_full  = {hi_field, lo_field};

    assign ext_short = XLEN'($signed(raw_short));
    assign ext_mid   = XLEN'($signed(raw_mid));
    assign ext_full  = XLEN'($signed(raw_full));

    always_comb begin
        unique case (dec.fsel)
            FS_SHORT: picked = ext_short;
            FS_MID:   picked = ext_mid;
            default:  picked = ext_full;
        endcase
    end

    assign scaled = picked << dec.shamt;

    always_comb begin
        if (dec.cls == IC_NONE)
            imm = '0;
        else if (dec.sp_rel)
            imm = scaled - XLEN'(SP_BIAS);
        else
            imm = scaled;
    end

endmodule

// File: rtl/cimm_basechk.sv
module cimm_basechk
    import cimm_pkg::*;
#(
    parameter int RA_W = 3
) (
    input  imm_dec_t        dec,
    input  logic [RA_W-1:0] reg_a,
    output logic            zero_base,
    output logic            sp_base,
    output logic            reserved
);
    logic ra_is_zero;

    assign ra_is_zero = (reg_a == '0);

    always_comb begin
        zero_base = 1'b0;
        reserved  = 1'b0;
        sp_base   = dec.sp_rel;
        unique case (dec.cls)
            IC_ADDI:  zero_base = ra_is_zero;
            IC_ADDIS: reserved  = ra_is_zero;
            default: ;
        endcase
    end

endmodule

// File: rtl/cimm_gen.sv
module cimm_gen
    import cimm_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int HI_W    = 5,
    parameter int LO_W    = 3,
    parameter int RA_W    = 3,
    parameter int SP_BIAS = 256
) (
    input  logic            fmt_valid,
    input  logic [2:0]      op_major,
    input  logic            op_minor,
    input  logic [HI_W-1:0] hi_field,
    input  logic [LO_W-1:0] lo_field,
    input  logic [RA_W-1:0] reg_a,
    output logic [XLEN-1:0] imm_out,
    output logic [2:0]      op_class,
    output logic            acc_dword,
    output logic            cmp_dword,
    output logic            use_zero_base,
    output logic            use_sp_base,
    output logic            reserved_enc
);
    imm_dec_t        dec;
    logic [XLEN-1:0] imm_raw;
    logic            zb, spb, rsv;

    cimm_classify u_cls (
        .op_major (op_major),
        .op_minor (op_minor),
        .hi_msb   (hi_field[HI_W-1]),
        .dec      (dec)
    );

    cimm_assemble #(
        .XLEN(XLEN), .HI_W(HI_W), .LO_W(LO_W), .SP_BIAS(SP_BIAS)
    ) u_asm (
        .dec      (dec),
        .hi_field (hi_field),
        .lo_field (lo_field),
        .imm      (imm_raw)
    );

    cimm_basechk #(.RA_W(RA_W)) u_base (
        .dec       (dec),
        .reg_a     (reg_a),
        .zero_base (zb),
        .sp_base   (spb),
        .reserved  (rsv)
    );

    always_comb begin
        if (fmt_valid) begin
            imm_out       = imm_raw;
            op_class      = dec.cls;
            acc_dword     = dec.dword;
            cmp_dword     = dec.cmp_dw;
            use_zero_base = zb;
            use_sp_base   = spb;
            reserved_enc  = rsv;
        end else begin
            imm_out       = '0;
            op_class      = IC_NONE;
            acc_dword     = 1'b0;
            cmp_dword     = 1'b0;
            use_zero_base = 1'b0;
            use_sp_base   = 1'b0;
            reserved_enc  = 1'b0;
        end
    end

endmodule

// File: rtl/cimm_gen_chk.sv
module cimm_gen_chk
    import cimm_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HI_W = 5,
    parameter int LO_W = 3,
    parameter int RA_W = 3
) (
    input logic            fmt_valid,
    input logic [2:0]      op_major,
    input logic            op_minor,
    input logic [HI_W-1:0] hi_field,
    input logic [LO_W-1:0] lo_field,
    input logic [RA_W-1:0] reg_a,
    input logic [XLEN-1:0] imm_out,
    input logic [2:0]      op_class,
    input logic            acc_dword,
    input logic            cmp_dword,
    input logic            use_zero_base,
    input logic            use_sp_base,
    input logic            reserved_enc
);
    logic known;
    logic signed [XLEN-1:0] simm;

    assign known = !$isunknown({fmt_valid, op_major, op_minor, hi_field, lo_field, reg_a});
    assign simm  = $signed(imm_out);

    always_comb begin
        if (known) begin
            a_r1_idle_quiet: assert (fmt_valid ||
                (imm_out == '0 && op_class == 3'd0 && !acc_dword && !cmp_dword &&
                 !use_zero_base && !use_sp_base && !reserved_enc))
                else $error("R1 outputs not quiet while idle");
            a_r2_addi_range: assert (op_class != IC_ADDI || (simm >= -8 && simm <= 7))
                else $error("R2 add-immediate out of range");
            a_r4_addis_aligned: assert (op_class != IC_ADDIS ||
                (imm_out[2:0] == 3'b000 && simm >= -1024 && simm <= 1016))
                else $error("R4 shifted add not aligned or out of range");
            a_r6_mem_aligned: assert (!is_mem(imm_class_e'(op_class)) ||
                (acc_dword ? (imm_out[2:0] == 3'b000) : (imm_out[1:0] == 2'b00)))
                else $error("R6 memory offset misaligned");
            a_r7_sp_major: assert (!use_sp_base || op_major == 3'b011)
                else $error("R7 stack base outside stack opcodes");
            a_r8_none_zero: assert (op_class != 3'd0 || imm_out == '0)
                else $error("R8 non-immediate op drove a value");
            a_r9_flags_exclusive: assert ($onehot0({use_zero_base, use_sp_base, reserved_enc}))
                else $error("R9 base flags overlap");
        end
    end

endmodule

bind cimm_gen cimm_gen_chk #(
    .XLEN(XLEN), .HI_W(HI_W), .LO_W(LO_W), .RA_W(RA_W)
) chk_i (.*);

// File: tb/cimm_gen_tb_top.sv
module cimm_gen_tb_top;

    logic        clk = 1'b0;
    logic        fmt_valid;
    logic [2:0]  op_major;
    logic        op_minor;
    logic [4:0]  hi_field;
    logic [2:0]  lo_field;
    logic [2:0]  reg_a;
    logic [63:0] imm_out;
    logic [2:0]  op_class;
    logic        acc_dword, cmp_dword, use_zero_base, use_sp_base, reserved_enc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cimm_gen dut_i (
        .fmt_valid     (fmt_valid),
        .op_major      (op_major),
        .op_minor      (op_minor),
        .hi_field      (hi_field),
        .lo_field      (lo_field),
        .reg_a         (reg_a),
        .imm_out       (imm_out),
        .op_class      (op_class),
        .acc_dword     (acc_dword),
        .cmp_dword     (cmp_dword),
        .use_zero_base (use_zero_base),
        .use_sp_base   (use_sp_base),
        .reserved_enc  (reserved_enc)
    );

    task automatic apply(input logic fv, input logic [2:0] maj, input logic mn,
                         input logic [4:0] hi, input logic [2:0] lo, input logic [2:0] ra);
        @(negedge clk);
        fmt_valid = fv; op_major = maj; op_minor = mn;
        hi_field = hi; lo_field = lo; reg_a = ra;
        #1;
    endtask

    // flags order: acc_dword, cmp_dword, use_zero_base, use_sp_base, reserved_enc
    task automatic expect_all(input string req, input logic signed [63:0] e_imm,
                              input logic [2:0] e_cls, input logic [4:0] e_flags);
        logic [71:0] got, exp;
        got = {imm_out, op_class, acc_dword, cmp_dword, use_zero_base, use_sp_base, reserved_enc};
        exp = {e_imm, e_cls, e_flags};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: imm/class/flags actual %h/%0d/%b expected %h/%0d/%b", req,
                     got[71:8], got[7:5], got[4:0], exp[71:8], exp[7:5], exp[4:0]);
        end
    endtask

    task automatic t_idle_r1;
        apply(1'b0, 3'b010, 1'b0, 5'b11111, 3'b111, 3'd2);
        expect_all("R1 idle addi", 0, 3'd0, 5'b00000);
        apply(1'b0, 3'b011, 1'b1, 5'b10000, 3'b010, 3'd0);
        expect_all("R1 idle sp store", 0, 3'd0, 5'b00000);
    endtask

    task automatic t_addi_r2_r3;
        apply(1'b1, 3'b010, 1'b0, 5'b00001, 3'b111, 3'd3);
        expect_all("R2 addi -1", -1, 3'd1, 5'b00000);
        apply(1'b1, 3'b010, 1'b0, 5'b11110, 3'b111, 3'd3);
        expect_all("R2 addi +7 upper hi ignored", 7, 3'd1, 5'b00000);
        apply(1'b1, 3'b010, 1'b0, 5'b00001, 3'b000, 3'd5);
        expect_all("R2 addi -8", -8, 3'd1, 5'b00000);
        apply(1'b1, 3'b010, 1'b0, 5'b00000, 3'b011, 3'd0);
        expect_all("R3 addi zero base li", 3, 3'd1, 5'b00100);
    endtask

    task automatic t_addis_r4;
        apply(1'b1, 3'b001, 1'b0, 5'b10000, 3'b000, 3'd2);
        expect_all("R4 addis -1024", -1024, 3'd2, 5'b00000);
        apply(1'b1, 3'b001, 1'b0, 5'b01111, 3'b111, 3'd2);
        expect_all("R4 addis +1016", 1016, 3'd2, 5'b00000);
        apply(1'b1, 3'b001, 1'b0, 5'b00000, 3'b001, 3'd0);
        expect_all("R4 addis zero base reserved", 8, 3'd2, 5'b00001);
    endtask

    task automatic t_cmpi_r5;
        apply(1'b1, 3'b010, 1'b1, 5'b01000, 3'b000, 3'd1);
        expect_all("R5 cmp doubleword -64", -64, 3'd3, 5'b01000);
        apply(1'b1, 3'b010, 1'b1, 5'b10111, 3'b111, 3'd0);
        expect_all("R5 cmp word +63", 63, 3'd3, 5'b00000);
    endtask

    task automatic t_mem_r6;
        apply(1'b1, 3'b101, 1'b0, 5'b11111, 3'b111, 3'd4);
        expect_all("R6 load dword -8", -8, 3'd4, 5'b10000);
        apply(1'b1, 3'b101, 1'b1, 5'b01111, 3'b111, 3'd4);
        expect_all("R6 load word 508", 508, 3'd4, 5'b00000);
        apply(1'b1, 3'b100, 1'b0, 5'b10000, 3'b000, 3'd0);
        expect_all("R6 store word -512", -512, 3'd5, 5'b00000);
        apply(1'b1, 3'b100, 1'b1, 5'b00000, 3'b001, 3'd6);
        expect_all("R6 store dword 8", 8, 3'd5, 5'b10000);
        apply(1'b1, 3'b110, 1'b1, 5'b00000, 3'b010, 3'd1);
        expect_all("R6 fp store dword 16", 16, 3'd7, 5'b10000);
        apply(1'b1, 3'b111, 1'b0, 5'b00000, 3'b001, 3'd1);
        expect_all("R6 fp load word 4", 4, 3'd6, 5'b00000);
        apply(1'b1, 3'b111, 1'b1, 5'b11111, 3'b110, 3'd1);
        expect_all("R6 fp load dword -16", -16, 3'd6, 5'b10000);
    endtask

    task automatic t_sp_r7;
        apply(1'b1, 3'b011, 1'b0, 5'b00000, 3'b001, 3'd2);
        expect_all("R7 sp load dword -248", -248, 3'd4, 5'b10010);
        apply(1'b1, 3'b011, 1'b0, 5'b11111, 3'b111, 3'd2);
        expect_all("R7 sp load word -260", -260, 3'd4, 5'b00010);
        apply(1'b1, 3'b011, 1'b1, 5'b10000, 3'b010, 3'd0);
        expect_all("R7 sp store dword -240", -240, 3'd5, 5'b10010);
        apply(1'b1, 3'b011, 1'b1, 5'b00111, 3'b111, 3'd0);
        expect_all("R7 sp store word -4", -4, 3'd5, 5'b00010);
    endtask

    task automatic t_none_r8_r9;
        apply(1'b1, 3'b000, 1'b0, 5'b11111, 3'b111, 3'd0);
        expect_all("R8 major 000.0 none", 0, 3'd0, 5'b00000);
        apply(1'b1, 3'b000, 1'b1, 5'b10101, 3'b101, 3'd7);
        expect_all("R8 major 000.1 none", 0, 3'd0, 5'b00000);
        apply(1'b1, 3'b001, 1'b1, 5'b11111, 3'b111, 3'd0);
        expect_all("R8 opcode 001.1 none", 0, 3'd0, 5'b00000);
        apply(1'b1, 3'b100, 1'b0, 5'b00000, 3'b000, 3'd0);
        expect_all("R9 memory op zero base no flag", 0, 3'd5, 5'b00000);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        fmt_valid = 1'b0; op_major = '0; op_minor = 1'b0;
        hi_field = '0; lo_field = '0; reg_a = '0;
        #1;
        expect_all("R1 reset state", 0, 3'd0, 5'b00000);
        t_idle_r1();
        t_addi_r2_r3();
        t_addis_r4();
        t_cmpi_r5();
        t_mem_r6();
        t_sp_r7();
        t_none_r8_r9();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule